// File: doc/BRIEF.md
# Port change interrupt detector

This block watches two 8-bit general-purpose ports and raises an active-low interrupt whenever a pin that is in input mode no longer matches the level the host last read from it. A serial-bus front end supplies three things: the pin levels, a per-pin direction setting with 1 meaning input, and one read-acknowledge strobe per port. That strobe pulses on the acknowledge clock of a read of the port.

The block passes the pins through a two-flop synchronizer. It keeps a reference snapshot for each port and compares the synchronized pins against it. The interrupt clears by itself when the pins go back to the snapshot. It also clears when the host reads the offending port, because the read reloads that port's snapshot from the current levels.

The output is modelled for an open-drain pad. There is a logical level, and there is a drive-low enable that the pad uses to pull the line down.

Top module: `port_chg_irq`

## Requirements
- R1: A level change on a pin whose direction bit is 1 (input) pulls `int_n_o` low at the third rising clock edge after the change. `int_n_o` is still high after the second edge.
- R2: A change on a pin whose direction bit is 0 (output) never pulls `int_n_o` low.
- R3: When every input pin returns to its snapshot value, `int_n_o` goes high again, with the same three-edge latency as R1.
- R4: A rising edge with `rd_ack_i[p]` high loads the snapshot of port p (pins 8p to 8p+7) from the synchronized pins. In that same edge the port's contribution to the interrupt is cleared, so `int_n_o` is high after that edge when no other mismatch remains.
- R5: A read of one port leaves the other port's snapshot untouched. A pending mismatch on the other port keeps `int_n_o` low.
- R6: A change that occurs after a read-clear is detected and signalled again.
- R7: A pin switched from output to input raises the interrupt if its level differs from its snapshot. `int_n_o` goes low at the second edge after the new direction is presented. If the level matches the snapshot, no interrupt is raised.
- R8: While `rst_n` is low, `int_n_o` is high, `int_oe_o` is low and every pin is treated as an input. A reset held for at least three clocks loads the snapshots from the current pins, so no interrupt follows reset while the pins are steady.
- R9: `int_oe_o` is high exactly when `int_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 16 | Asynchronous pin levels; bits 7:0 port 0, 15:8 port 1 |
| dir_in_i | input | 16 | Per-pin direction, 1 = input, 0 = output |
| rd_ack_i | input | 2 | Per-port read-acknowledge strobe |
| int_n_o | output | 1 | Interrupt level, active low |
| int_oe_o | output | 1 | Drive-low enable for the open-drain pad |

## Verification
The bench counts clock edges after each pin change so that it can catch a design with the wrong number of synchronizer stages. It then reads one port while the other port holds a mismatch. A design that shares one snapshot between the ports would wrongly deassert the interrupt in that case. The bench also flips output-mode pins, and switches pins to input both with and without a level mismatch. This exposes a design that does not mask by direction, and one that ignores direction changes. Finally, it checks that the read clears the interrupt on the acknowledge edge itself and not one clock later.

// File: rtl/port_chg_irq.sv
module port_chg_irq #(
  parameter int PW = 8,
  parameter int NP = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PW*NP-1:0]    pin_i,
  input  logic [PW*NP-1:0]    dir_in_i,
  input  logic [NP-1:0]       rd_ack_i,
  output logic                int_n_o,
  output logic                int_oe_o
);
  localparam int TW = PW * NP;

  logic [TW-1:0] s1_q, s2_q, dir_q, snap_q, snap_n;
  logic          int_q;

  always_ff @(posedge clk) begin
    s1_q <= pin_i;
    s2_q <= s1_q;
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign snap_n[p*PW +: PW] = rd_ack_i[p] ? s2_q[p*PW +: PW] : snap_q[p*PW +: PW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= s2_q;
      dir_q  <= '1;
      int_q  <= 1'b0;
    end else begin
      snap_q <= snap_n;
      dir_q  <= dir_in_i;
      int_q  <= |(dir_q & (s2_q ^ snap_n));
    end
  end

  assign int_n_o  = ~int_q;
  assign int_oe_o = int_q;
endmodule

// File: rtl/port_chg_irq_chk.sv
module port_chg_irq_chk #(
  parameter int PW = 8,
  parameter int NP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PW*NP-1:0] sync_q,
  input logic [PW*NP-1:0] dir_q,
  input logic [PW*NP-1:0] snap_q,
  input logic [NP-1:0]    rd_ack,
  input logic             int_n,
  input logic             int_oe
);
  logic mism;
  assign mism = |(dir_q & (sync_q ^ snap_q));

  AST_RAISE_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mism && rd_ack == '0) |=> !int_n); // R1
  AST_QUIET_WHEN_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mism && rd_ack == '0) |=> int_n); // R3
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack == '0) |=> $stable(snap_q)); // R5
  AST_READ_LOAD_P0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack[0] |=> snap_q[PW-1:0] == $past(sync_q[PW-1:0])); // R4
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (int_n && !int_oe)); // R8
endmodule

bind port_chg_irq port_chg_irq_chk #(.PW(PW), .NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_q(s2_q), .dir_q(dir_q), .snap_q(snap_q),
  .rd_ack(rd_ack_i), .int_n(int_n_o), .int_oe(int_oe_o)
);

// File: tb/port_chg_irq_bench.sv
`timescale 1ns/1ps
module port_chg_irq_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] pin = 16'h00A5;
  logic [15:0] dir = 16'hFFFF;
  logic [1:0]  ack = 2'b00;
  logic        int_n, int_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_chg_irq u_port_chg_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_in_i(dir),
    .rd_ack_i(ack), .int_n_o(int_n), .int_oe_o(int_oe)
  );

  // pins, direction, read strobe, expected int_n after settling
  typedef struct packed { logic [15:0] p; logic [15:0] d; logic [1:0] a; logic e; } vec_t;
  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{16'h00A5, 16'hFFFF, 2'b00, 1'b1}, // R8 steady after reset
    '{16'h00A4, 16'hFFFF, 2'b00, 1'b0}, // R1 falling pin port 0
    '{16'h00A5, 16'hFFFF, 2'b00, 1'b1}, // R3 return to snapshot
    '{16'h01A5, 16'hFFFF, 2'b00, 1'b0}, // R1 rising pin port 1
    '{16'h01A5, 16'hFFFF, 2'b01, 1'b0}, // R5 port 0 read keeps port 1 pending
    '{16'h01A5, 16'hFFFF, 2'b10, 1'b1}, // R4 port 1 read clears
    '{16'h00A5, 16'hFFFF, 2'b00, 1'b0}, // R6 change after clear
    '{16'h00A5, 16'hFFFF, 2'b10, 1'b1}, // R4
    '{16'h00A5, 16'hFFF0, 2'b00, 1'b1}, // R2 low nibble to output
    '{16'h00AA, 16'hFFF0, 2'b00, 1'b1}, // R2 output pins toggle
    '{16'h00AA, 16'hFFFF, 2'b00, 1'b0}, // R7 back to input, mismatch
    '{16'h00AA, 16'hFFFF, 2'b01, 1'b1}, // R4
    '{16'h00AA, 16'h0000, 2'b00, 1'b1}, // R2 all outputs
    '{16'h5555, 16'h0000, 2'b00, 1'b1}, // R2 every pin toggles
    '{16'h5555, 16'hFF00, 2'b00, 1'b0}, // R7 port 1 to input, mismatch
    '{16'h5555, 16'hFF00, 2'b10, 1'b1}, // R4
    '{16'h55AA, 16'hFFFF, 2'b00, 1'b1}  // R7 to input with matching level
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    edges(2);
    chk("R8 int_n in reset", int_n, 1'b1);
    chk("R8 int_oe in reset", int_oe, 1'b0);
    edges(2);
    rst_n = 1;
    edges(1);
    for (int i = 0; i < NV; i++) begin
      pin = VT[i].p; dir = VT[i].d; ack = VT[i].a;
      edges(1);
      ack = 2'b00;
      edges(3);
      chk($sformatf("vector %0d int_n", i), int_n, VT[i].e);
      chk("R9 int_oe mirrors", int_oe, ~VT[i].e);
    end
    // R1 latency: pins 55AA, snap 55AA, all inputs
    pin = 16'h55AB;
    edges(2);
    chk("R1 not yet after two edges", int_n, 1'b1);
    edges(1);
    chk("R1 asserted at third edge", int_n, 1'b0);
    // R4 clear on the acknowledge edge itself
    ack = 2'b01;
    edges(1);
    ack = 2'b00;
    chk("R4 clear same edge", int_n, 1'b1);
    // R3 latency of self-clear
    pin = 16'h45AB;
    edges(3);
    chk("R1 port 1 change", int_n, 1'b0);
    pin = 16'h55AB;
    edges(2);
    chk("R3 still low after two edges", int_n, 1'b0);
    edges(1);
    chk("R3 cleared at third edge", int_n, 1'b1);
    // R7 latency from direction change
    dir = 16'hFFFE;
    edges(2);
    pin = 16'h55AA;
    edges(3);
    chk("R2 masked output pin", int_n, 1'b1);
    dir = 16'hFFFF;
    edges(1);
    chk("R7 not yet after one edge", int_n, 1'b1);
    edges(1);
    chk("R7 raised at second edge", int_n, 1'b0);
    // R8 reset reloads snapshot from pins
    rst_n = 0;
    edges(4);
    chk("R8 int_n in reset", int_n, 1'b1);
    rst_n = 1;
    edges(4);
    chk("R8 no interrupt after reset", int_n, 1'b1);
    chk("R9 oe low after reset", int_oe, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule